// File: doc/BRIEF.md
# Beacon-Driven Sleep/Wake Controller

This block decides when a wireless MAC's radio sleeps and when it wakes. The host puts the station to sleep with a sleep request. The block can then bring it back in three ways. The host can drop the request. The host can raise a force-wake bit. Or, with automatic waking enabled, the block counts target-beacon-time pulses and waits a further delay in time units before it starts waking.

Waking is not instant. The block first raises a radio-enable request and reports itself awake. It reports the radio as ready only after a programmed wake-up latency, counted in time-unit ticks. The beacon timer that makes the pulses and the time-unit ticks is outside this block, and so is the radio hardware.

All pins are plain control and status levels or single-cycle pulses. None of them carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `ps_beacon_ctrl`

## Requirements
- R1: After reset the block is awake: `pwr_awake`=1, `radio_en`=1, `radio_rdy`=1.
- R2: While awake, a rise of `sleep_req` (low in the previous cycle, high now) with `force_wake` low puts the block to sleep on the next clock edge: all three outputs read 0.
- R3: `force_wake` has priority over sleeping. A rise of `sleep_req` while `force_wake` is high leaves the block awake. `force_wake` high while asleep or in the beacon delay starts the wake sequence on the next edge.
- R4: Dropping `sleep_req` to 0 while asleep or in the beacon delay starts the wake sequence on the next edge.
- R5: With `auto_wake` high, the block counts beacon pulses from the moment it enters sleep. The pulse numbered `tbtt_num`+1 starts the delay phase, so a value of 0 means the first pulse. Beacon pulses have no effect while `auto_wake` is 0.
- R6: The delay phase lasts until `wake_dly` time-unit ticks have been counted. A tick in the same cycle as the pulse that starts the phase does not count. The wake sequence starts on the edge after the count reaches zero, so a value of 0 wakes one cycle after the phase begins.
- R7: During the wake sequence `radio_en`=1 and `pwr_awake`=1 while `radio_rdy`=0. `radio_rdy` rises on the edge after `wake_lat` ticks have been counted in this phase. A value of 0 makes it ready one cycle after the wake sequence starts.
- R8: `pwr_awake` reads 1 when awake or waking and 0 when asleep or in the delay. `radio_rdy` is never 1 without `radio_en`.
- R9: `wake_dly` and `wake_lat` are sampled when their phase begins. Changing them mid-phase does not change that phase's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbtt_pulse | input | 1 | One-cycle target-beacon-time pulse |
| tu_tick | input | 1 | One-cycle pulse per time unit |
| sleep_req | input | 1 | Host request to sleep (level) |
| force_wake | input | 1 | Host force-wake (level, wins over sleep) |
| auto_wake | input | 1 | Enables beacon-counted automatic waking |
| tbtt_num | input | 7 | Beacon pulses to skip before the delay phase |
| wake_dly | input | 8 | Delay after the last counted beacon, in ticks |
| wake_lat | input | 4 | Wake-up latency, in ticks |
| pwr_awake | output | 1 | Power state: 1 awake, 0 asleep |
| radio_en | output | 1 | Radio enable request |
| radio_rdy | output | 1 | Radio ready: 1 ready, 0 not ready |

## Verification
The main function is driven with three beacon-count and delay settings.

- A count of 2 with ticks spread between pulses checks that pulses are counted, not merely detected.
- Zero count, delay and latency expose off-by-one errors at each phase boundary.
- A delay setting changed during its own phase separates sampled values from live ones.

Manual wake by clearing the request, force-wake in both the sleep and the delay state, and force-wake held across a sleep rise show each exit's priority. A long random stretch, compared every cycle against a behavioural model, mixes coincident pulses, ticks and host bits.

// File: rtl/ps_beacon_pkg.sv
package ps_beacon_pkg;
  typedef enum logic [1:0] {
    PS_AWAKE  = 2'd0,
    PS_SLEEP  = 2'd1,
    PS_DELAY  = 2'd2,
    PS_WAKING = 2'd3
  } ps_state_e;
endpackage

// File: rtl/ps_tbtt_counter.sv
module ps_tbtt_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             pulse,
  input  logic [CNT_W-1:0] target,
  output logic             hit
);
  logic [CNT_W-1:0] seen_q;

  // the pulse that matches the target ends the count
  assign hit = pulse && (seen_q == target);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) seen_q <= '0;
    else if (pulse && !hit) seen_q <= seen_q + 1'b1;
  end

  // R5: counting only ever moves up by one on a pulse
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !pulse) |=> $stable(seen_q));
endmodule

// File: rtl/ps_tu_timer.sv
module ps_tu_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             done
);
  logic [CNT_W-1:0] rem_q;

  assign done = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (tick && !done) rem_q <= rem_q - 1'b1;
  end

  // R9: the remaining count only changes on a load or a tick
  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(rem_q));
endmodule

// File: rtl/ps_beacon_ctrl.sv
module ps_beacon_ctrl #(
  parameter int TBTT_W = 7,
  parameter int DLY_W  = 8,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbtt_pulse,
  input  logic              tu_tick,
  input  logic              sleep_req,
  input  logic              force_wake,
  input  logic              auto_wake,
  input  logic [TBTT_W-1:0] tbtt_num,
  input  logic [DLY_W-1:0]  wake_dly,
  input  logic [LAT_W-1:0]  wake_lat,
  output logic              pwr_awake,
  output logic              radio_en,
  output logic              radio_rdy
);
  import ps_beacon_pkg::*;

  ps_state_e state_q, state_d;
  logic      sleep_q;
  logic      sleep_rise;
  logic      host_wake;
  logic      beacon_ok;
  logic      beacon_hit;
  logic      dly_load, dly_done;
  logic      lat_load, lat_done;

  assign sleep_rise = sleep_req && !sleep_q;
  // force-wake wins; a dropped request also wakes
  assign host_wake  = force_wake || !sleep_req;
  assign beacon_ok  = tbtt_pulse && auto_wake && (state_q == PS_SLEEP) && !host_wake;

  ps_tbtt_counter #(.CNT_W(TBTT_W)) u_tbtt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state_q == PS_AWAKE),
    .pulse  (beacon_ok),
    .target (tbtt_num),
    .hit    (beacon_hit)
  );

  ps_tu_timer #(.CNT_W(DLY_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (wake_dly),
    .tick     (tu_tick && (state_q == PS_DELAY)),
    .done     (dly_done)
  );

  ps_tu_timer #(.CNT_W(LAT_W)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (lat_load),
    .load_val (wake_lat),
    .tick     (tu_tick && (state_q == PS_WAKING)),
    .done     (lat_done)
  );

  always_comb begin
    state_d  = state_q;
    dly_load = 1'b0;
    lat_load = 1'b0;
    unique case (state_q)
      PS_AWAKE: begin
        if (sleep_rise && !force_wake) state_d = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (host_wake) begin
          state_d  = PS_WAKING;
          lat_load = 1'b1;
        end else if (beacon_hit) begin
          state_d  = PS_DELAY;
          dly_load = 1'b1;
        end
      end
      PS_DELAY: begin
        if (host_wake || dly_done) begin
          state_d  = PS_WAKING;
          lat_load = 1'b1;
        end
      end
      PS_WAKING: begin
        if (lat_done) state_d = PS_AWAKE;
      end
      default: state_d = PS_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PS_AWAKE;
      sleep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sleep_q <= sleep_req;
    end
  end

  assign pwr_awake = (state_q == PS_AWAKE) || (state_q == PS_WAKING);
  assign radio_en  = (state_q == PS_AWAKE) || (state_q == PS_WAKING);
  assign radio_rdy = (state_q == PS_AWAKE);

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_AWAKE && sleep_req && !sleep_q && !force_wake) |=> !pwr_awake);

  p_force_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_SLEEP || state_q == PS_DELAY) && force_wake) |=> (radio_en && !radio_rdy));

  p_clear_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_SLEEP || state_q == PS_DELAY) && !sleep_req) |=> radio_en);

  p_manual_ignores_beacon_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP && !auto_wake && sleep_req && !force_wake) |=> (state_q == PS_SLEEP));

  p_ready_after_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(radio_rdy) |-> $past(radio_en));

  p_ready_implies_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    radio_rdy |-> radio_en);
endmodule

// File: tb/ps_beacon_ctrl_tb_top.sv
module ps_beacon_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbtt_pulse = 1'b0, tu_tick = 1'b0;
  logic sleep_req = 1'b0, force_wake = 1'b0, auto_wake = 1'b0;
  logic [6:0] tbtt_num = '0;
  logic [7:0] wake_dly = '0;
  logic [3:0] wake_lat = '0;
  logic pwr_awake, radio_en, radio_rdy;

  int total = 0;
  int bad = 0;

  // reference model: 0 awake, 1 asleep, 2 delay, 3 waking
  int m_ph = 0, m_seen = 0, m_rem = 0;
  bit m_prev = 0;

  always #5 clk = ~clk;

  ps_beacon_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tbtt_pulse(tbtt_pulse), .tu_tick(tu_tick),
    .sleep_req(sleep_req), .force_wake(force_wake), .auto_wake(auto_wake),
    .tbtt_num(tbtt_num), .wake_dly(wake_dly), .wake_lat(wake_lat),
    .pwr_awake(pwr_awake), .radio_en(radio_en), .radio_rdy(radio_rdy)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_seen = 0; m_rem = 0; m_prev = 0;
    end else begin
      case (m_ph)
        0: if (sleep_req && !m_prev && !force_wake) begin m_ph = 1; m_seen = 0; end
        1: if (force_wake || !sleep_req) begin m_ph = 3; m_rem = wake_lat; end
           else if (auto_wake && tbtt_pulse) begin
             if (m_seen == tbtt_num) begin m_ph = 2; m_rem = wake_dly; end
             else m_seen++;
           end
        2: if (force_wake || !sleep_req || m_rem == 0) begin m_ph = 3; m_rem = wake_lat; end
           else if (tu_tick) m_rem--;
        default: if (m_rem == 0) m_ph = 0;
                 else if (tu_tick) m_rem--;
      endcase
      m_prev = sleep_req;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8", "pwr_awake", pwr_awake, (m_ph == 0 || m_ph == 3));
      check("R7", "radio_en", radio_en, (m_ph == 0 || m_ph == 3));
      check("R7", "radio_rdy", radio_rdy, (m_ph == 0));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tbtt();
    tbtt_pulse = 1; step(1); tbtt_pulse = 0;
  endtask

  task automatic ticks(int n);
    tu_tick = 1; step(n); tu_tick = 0;
  endtask

  task automatic outs(string tag, int ps, int en, int rdy);
    check(tag, "pwr_awake", pwr_awake, ps);
    check(tag, "radio_en", radio_en, en);
    check(tag, "radio_rdy", radio_rdy, rdy);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    outs("R1", 1, 1, 1);

    // R2 sleep entry; R5 beacons ignored with auto_wake=0; R4 clear to wake; R7 latency 3
    wake_lat = 3;
    sleep_req = 1; step(1);
    outs("R2", 0, 0, 0);
    pulse_tbtt(); step(2); pulse_tbtt(); ticks(2);
    outs("R5", 0, 0, 0);
    sleep_req = 0; step(1);
    outs("R4", 1, 1, 0);
    ticks(3);
    outs("R7", 1, 1, 0);
    step(1);
    outs("R7", 1, 1, 1);

    // R5 count 2: third pulse starts delay; R6 delay 2 with coincident tick ignored
    auto_wake = 1; tbtt_num = 2; wake_dly = 2; wake_lat = 1;
    sleep_req = 1; step(1);
    pulse_tbtt(); step(1); ticks(1); pulse_tbtt(); step(2);
    outs("R5", 0, 0, 0);
    tbtt_pulse = 1; tu_tick = 1; step(1); tbtt_pulse = 0; tu_tick = 0;
    outs("R5", 0, 0, 0);
    ticks(1);
    outs("R6", 0, 0, 0);
    ticks(1);
    outs("R6", 0, 0, 0);
    step(1);
    outs("R6", 1, 1, 0);
    ticks(1); step(1);
    outs("R7", 1, 1, 1);

    // R5/R6/R7 zero count, delay and latency
    sleep_req = 0; step(1);
    tbtt_num = 0; wake_dly = 0; wake_lat = 0;
    sleep_req = 1; step(1);
    pulse_tbtt();
    outs("R5", 0, 0, 0);
    step(1);
    outs("R6", 1, 1, 0);
    step(1);
    outs("R7", 1, 1, 1);

    // R3 force-wake held across a sleep rise keeps the block awake
    sleep_req = 0; step(1);
    force_wake = 1; sleep_req = 1; step(2);
    outs("R3", 1, 1, 1);
    force_wake = 0; sleep_req = 0; step(1);
    sleep_req = 1; step(1);
    outs("R2", 0, 0, 0);
    wake_lat = 2;
    force_wake = 1; step(1);
    outs("R3", 1, 1, 0);
    force_wake = 0; ticks(2); step(1);
    outs("R3", 1, 1, 1);

    // R3 force-wake from the delay phase; R9 delay sampled at phase start
    sleep_req = 0; step(1);
    wake_dly = 3; wake_lat = 0;
    sleep_req = 1; step(1);
    pulse_tbtt();
    wake_dly = 0; step(2);
    outs("R9", 0, 0, 0);
    ticks(3); step(1);
    outs("R9", 1, 1, 0);
    step(1);
    sleep_req = 0; step(1);
    wake_dly = 50;
    sleep_req = 1; step(1);
    pulse_tbtt(); step(1);
    force_wake = 1; step(1); force_wake = 0;
    outs("R3", 1, 1, 0);

    // random mix, compared every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      tbtt_pulse = ($urandom_range(0, 7) == 0);
      tu_tick    = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 40) == 0) sleep_req = ~sleep_req;
      force_wake = ($urandom_range(0, 60) == 0);
      if ($urandom_range(0, 200) == 0) auto_wake = ~auto_wake;
      if ($urandom_range(0, 100) == 0) begin
        tbtt_num = 7'($urandom_range(0, 3));
        wake_dly = 8'($urandom_range(0, 6));
        wake_lat = 4'($urandom_range(0, 5));
      end
      step(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule